// File: doc/BRIEF.md
# Bit-Serial Multiply-Add Processing Element

This element forms Y = A + B×M for one sample per word cycle in a bit-serial audio-synthesis datapath. B and A arrive on one-bit lines, least-significant bit first. The coefficient M is a two's-complement value that is read in parallel. A word cycle lasts 2N bit clocks. A one-clock frame pulse marks bit 0 of each word.

In the first half of a word, the element shifts B in and moves it into a holding register. In the same half it sends the previous word's result out. In the second half, B is not looked at. The coefficient bits are applied one per clock to a shift-add multiplier against the held B. A arrives during that same half, and the element adds it to the upper half of the product.

The N low product bits are dropped by truncation. The N-bit sum wraps. It leaves the element exactly one word time after B's first bit went in. During the second half of every word, the serial output carries zeros.

Top module: `smac_pe`

## Requirements
- R1: For each framed word, the N-bit serial result equals (A + floor(B×M / 2^N)) mod 2^N. B, M and A are N-bit two's complement, so M acts as the fraction M/2^N. Y leaves on yOut least-significant bit first.
- R2: Bit k of a word's result (k = 0..N-1) is on yOut in the clock that lies 2N + k clocks after that word's frame cycle. Bit 0 therefore coincides with the next frame pulse.
- R3: In clocks N..2N-1 of every word, counted from the frame cycle as clock 0, yOut is 0.
- R4: B is taken from bIn in clocks 0..N-1 of a word. The value of bIn in clocks N..2N-1 does not change any result.
- R5: A is taken from aIn in clocks N..2N-1 of a word. The value of aIn in clocks 0..N-1 does not change any result.
- R6: coefIn is captured only in the frame cycle. Changes on coefIn in clocks 1..2N-1 do not change the current word's result.
- R7: With A = 0, the element is a plain scaler. The extreme case B = M = -2^(N-1) gives 2^(N-2).
- R8: An upper-half sum beyond the N-bit range wraps modulo 2^N without saturation.
- R9: Dropped low product bits truncate toward minus infinity. For example, B = -1, M = 1, A = 5 gives 4.
- R10: After reset, yOut stays 0 until results of a framed word are due. Activity on bIn and aIn before the first frame pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameIn | input | 1 | One-clock pulse marking bit 0 of a word |
| bIn | input | 1 | Serial multiplicand B, LSB first, first half of word |
| aIn | input | 1 | Serial addend A, LSB first, second half of word |
| coefIn | input | N | Parallel two's-complement coefficient M, captured at frame |
| yOut | output | 1 | Serial result, LSB first, first half of the following word |

## Verification
A table of operand triples runs back to back through consecutive frames. The triples use mixed signs, full-scale magnitudes and a zero coefficient, so a wrong sign treatment of the last coefficient bit shows up as a mismatch. A skewed serial alignment also shows up that way.

Directed words place a single set bit in A to pin the output latency to the exact clock. Other directed words put random noise on the unused halves of bIn and aIn, and glitch the coefficient mid-word, to show that each input is sampled only in its own window. The most-negative product, a wrapping sum and a negative sub-LSB product test the saturation-free wrap and the truncation direction.

// File: rtl/smac_pkg.sv
package smac_pkg;

  // Strobes issued by the word-cycle sequencer to the datapath
  typedef struct packed {
    logic latchCoef;  // capture the parallel coefficient
    logic shiftB;     // shift serial B into the capture register
    logic holdB;      // move the complete B into the multiplier hold register
    logic clearAcc;   // zero the partial-product accumulator
    logic mulStep;    // perform one shift-add step
    logic lastStep;   // the step uses the coefficient sign bit (subtract)
    logic shiftA;     // shift serial A into its register
    logic finish;     // form the final sum and load the output shifter
    logic drainY;     // present and shift the output word
  } smacCtrl_t;

endpackage

// File: rtl/smac_seq.sv
module smac_seq
  import smac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameIn,
  output smacCtrl_t              ctrlS,
  output logic [$clog2(N)-1:0]   stepIdx
);

  localparam int CW = $clog2(2 * N);
  localparam int SW = $clog2(N);
  localparam logic [CW-1:0] LAST_POS = CW'(2 * N - 1);
  localparam logic [CW-1:0] HALF_POS = CW'(N);
  localparam logic [CW-1:0] MID_POS  = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] phase;
  logic          armed;
  logic          active;

  // A frame pulse forces position zero regardless of the free-running count
  assign phase  = frameIn ? '0 : cnt;
  assign active = armed | frameIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (frameIn) armed <= 1'b1;
      if (phase == LAST_POS) cnt <= '0;
      else                   cnt <= phase + 1'b1;
    end
  end

  always_comb begin
    ctrlS = '0;
    if (active) begin
      ctrlS.latchCoef = frameIn;
      ctrlS.shiftB    = (phase <  HALF_POS);
      ctrlS.holdB     = (phase == MID_POS);
      ctrlS.clearAcc  = (phase == MID_POS);
      ctrlS.mulStep   = (phase >= HALF_POS);
      ctrlS.lastStep  = (phase == LAST_POS);
      ctrlS.shiftA    = (phase >= HALF_POS);
      ctrlS.finish    = (phase == LAST_POS);
      ctrlS.drainY    = (phase <  HALF_POS);
    end
  end

  assign stepIdx = SW'(phase - HALF_POS);

endmodule

// File: rtl/smac_mulstep.sv
module smac_mulstep #(
  parameter int N = 16
) (
  input  logic signed [N:0]   accIn,
  input  logic        [N-1:0] bVal,
  input  logic                mBit,
  input  logic                negate,
  output logic signed [N:0]   accOut
);

  logic        [N-1:0] ppBits;
  logic signed [N+1:0] addend;
  logic signed [N+1:0] sum;

  // One partial-product gate per multiplicand bit
  for (genvar i = 0; i < N; i++) begin : g_pp
    assign ppBits[i] = bVal[i] & mBit;
  end

  always_comb begin
    addend = $signed({{2{ppBits[N-1]}}, ppBits});
    if (negate) addend = -addend;
    sum    = $signed({accIn[N], accIn}) + addend;
  end

  // Arithmetic halving drops one low product bit per step (truncation)
  assign accOut = sum[N+1:1];

endmodule

// File: rtl/smac_dp.sv
module smac_dp
  import smac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  smacCtrl_t            ctrlS,
  input  logic [$clog2(N)-1:0] stepIdx,
  input  logic                 bIn,
  input  logic                 aIn,
  input  logic [N-1:0]         coefIn,
  output logic                 yOut
);

  logic        [N-1:0] bShift;
  logic        [N-1:0] bHold;
  logic        [N-1:0] mReg;
  logic        [N-1:0] aShift;
  logic        [N-1:0] yShift;
  logic        [N-1:0] bFull;
  logic        [N-1:0] aFull;
  logic signed [N:0]   acc;
  logic signed [N:0]   accNext;

  assign bFull = {bIn, bShift[N-1:1]};
  assign aFull = {aIn, aShift[N-1:1]};

  smac_mulstep #(.N(N)) u_step (
    .accIn  (acc),
    .bVal   (bHold),
    .mBit   (mReg[stepIdx]),
    .negate (ctrlS.lastStep),
    .accOut (accNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bShift <= '0;
      bHold  <= '0;
      mReg   <= '0;
      aShift <= '0;
      acc    <= '0;
    end else begin
      if (ctrlS.latchCoef) mReg   <= coefIn;
      if (ctrlS.shiftB)    bShift <= bFull;
      if (ctrlS.holdB)     bHold  <= bFull;
      if (ctrlS.shiftA)    aShift <= aFull;
      if (ctrlS.clearAcc)     acc <= '0;
      else if (ctrlS.mulStep) acc <= accNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yShift <= '0;
    end else if (ctrlS.finish) begin
      yShift <= accNext[N-1:0] + aFull;
    end else if (ctrlS.drainY) begin
      yShift <= {1'b0, yShift[N-1:1]};
    end
  end

  assign yOut = ctrlS.drainY & yShift[0];

endmodule

// File: rtl/smac_pe.sv
module smac_pe
  import smac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameIn,
  input  logic         bIn,
  input  logic         aIn,
  input  logic [N-1:0] coefIn,
  output logic         yOut
);

  smacCtrl_t            ctrlS;
  logic [$clog2(N)-1:0] stepIdx;

  smac_seq #(.N(N)) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .frameIn (frameIn),
    .ctrlS   (ctrlS),
    .stepIdx (stepIdx)
  );

  smac_dp #(.N(N)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlS   (ctrlS),
    .stepIdx (stepIdx),
    .bIn     (bIn),
    .aIn     (aIn),
    .coefIn  (coefIn),
    .yOut    (yOut)
  );

endmodule

// File: rtl/smac_pe_chk.sv
module smac_pe_chk #(
  parameter int N = 16
) (
  input logic clk,
  input logic rstN,
  input logic frameIn,
  input logic yOut,
  input logic shiftB,
  input logic holdB,
  input logic mulStep,
  input logic finish
);

  localparam int CW = $clog2(2 * N);

  logic [CW-1:0] chkPos;
  logic [CW-1:0] posNow;
  logic          seen;

  assign posNow = frameIn ? '0 : chkPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkPos <= '0;
      seen   <= 1'b0;
    end else begin
      if (frameIn) seen <= 1'b1;
      if (posNow == CW'(2 * N - 1)) chkPos <= '0;
      else                          chkPos <= posNow + 1'b1;
    end
  end

  // R3: the second half of every word is silent
  a_r3_idle_half_zero: assert property (@(posedge clk) disable iff (!rstN)
    (seen && posNow >= CW'(N)) |-> !yOut);

  // R10: nothing leaves the element before the first frame
  a_r10_quiet_until_frame: assert property (@(posedge clk) disable iff (!rstN)
    !seen |-> !yOut);

  // R4: the complete multiplicand is held at the end of the first half
  a_r4_hold_at_mid: assert property (@(posedge clk) disable iff (!rstN)
    (seen && posNow == CW'(N - 1)) |-> holdB);

  // R2: the result is formed in the last clock of the word
  a_r2_finish_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (seen && posNow == CW'(2 * N - 1)) |-> finish);

  // R4: capture and multiply halves never overlap
  a_r4_halves_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> $onehot({shiftB, mulStep}));

endmodule

bind smac_pe smac_pe_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .frameIn (frameIn),
  .yOut    (yOut),
  .shiftB  (ctrlS.shiftB),
  .holdB   (ctrlS.holdB),
  .mulStep (ctrlS.mulStep),
  .finish  (ctrlS.finish)
);

// File: tb/smac_pe_bench.sv
module smac_pe_bench;

  localparam int N  = 16;
  localparam int NV = 8;

  typedef struct packed {
    logic [N-1:0] b;
    logic [N-1:0] m;
    logic [N-1:0] a;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{b: 16'h1234, m: 16'h4000, a: 16'h0000},
    '{b: 16'h7FFF, m: 16'h7FFF, a: 16'h0010},
    '{b: 16'h8000, m: 16'h7FFF, a: 16'h0100},
    '{b: 16'hFFFF, m: 16'hFFFF, a: 16'hFFFF},
    '{b: 16'h5A5A, m: 16'h0000, a: 16'h1357},
    '{b: 16'hC3A1, m: 16'h2B7D, a: 16'h8001},
    '{b: 16'h0001, m: 16'h8000, a: 16'h0042},
    '{b: 16'h6E91, m: 16'hD00F, a: 16'h7FF0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         frameIn = 1'b0;
  logic         bIn = 1'b0;
  logic         aIn = 1'b0;
  logic [N-1:0] coefIn = '0;
  logic         yOut;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  smac_pe #(.N(N)) u_smac_pe (
    .clk     (clk),
    .rstN    (rstN),
    .frameIn (frameIn),
    .bIn     (bIn),
    .aIn     (aIn),
    .coefIn  (coefIn),
    .yOut    (yOut)
  );

  function automatic logic [N-1:0] refY(logic [N-1:0] b, logic [N-1:0] m, logic [N-1:0] a);
    logic signed [2*N-1:0] p;
    p = $signed(b) * $signed(m);
    return a + N'(p >>> N);
  endfunction

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One framed word; returns the result bits of the previous word
  task automatic doWord(input logic [N-1:0] b, input logic [N-1:0] m, input logic [N-1:0] a,
                        input bit noiseB, input bit noiseA, input bit coefGlitch,
                        output logic [N-1:0] prevY);
    bit zeroOk = 1'b1;
    prevY = '0;
    for (int k = 0; k < 2 * N; k++) begin
      @(negedge clk);
      frameIn = (k == 0);
      bIn     = (k < N) ? b[k] : (noiseB ? 1'($urandom) : 1'b0);
      aIn     = (k >= N) ? a[k-N] : (noiseA ? 1'($urandom) : 1'b0);
      if (k == 0)          coefIn = m;
      else if (coefGlitch) coefIn = N'($urandom);
      #1;
      if (k < N) prevY[k] = yOut;
      else if (yOut !== 1'b0) zeroOk = 1'b0;
    end
    check("R3 silent second half", N'(!zeroOk), '0);
  endtask

  task automatic runOne(string req, logic [N-1:0] b, logic [N-1:0] m, logic [N-1:0] a,
                        bit noiseB, bit noiseA, bit coefGlitch);
    logic [N-1:0] got;
    doWord(b, m, a, noiseB, noiseA, coefGlitch, got);
    doWord('0, '0, '0, 1'b0, 1'b0, 1'b0, got);
    check(req, got, refY(b, m, a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] got;
    bit quiet;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R10: serial activity without a frame leaves the output low
    quiet = 1'b1;
    for (int k = 0; k < 3 * N; k++) begin
      @(negedge clk);
      bIn = 1'b1;
      aIn = 1'b1;
      coefIn = '1;
      #1;
      if (yOut !== 1'b0) quiet = 1'b0;
    end
    check("R10 quiet before first frame", N'(!quiet), '0);

    // R1/R2: back-to-back table words, each result one word later
    for (int i = 0; i < NV; i++) begin
      doWord(VECS[i].b, VECS[i].m, VECS[i].a, 1'b0, 1'b0, 1'b0, got);
      if (i > 0)
        check("R1 R2 table word", got, refY(VECS[i-1].b, VECS[i-1].m, VECS[i-1].a));
    end
    doWord('0, '0, '0, 1'b0, 1'b0, 1'b0, got);
    check("R1 R2 table word", got, refY(VECS[NV-1].b, VECS[NV-1].m, VECS[NV-1].a));

    // R2: a single set bit pins the latency to the next frame
    runOne("R2 latency bit0", 16'h0000, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0);
    runOne("R2 latency msb", 16'h0000, 16'h0000, 16'h8000, 1'b0, 1'b0, 1'b0);

    // R4, R5, R6: inputs outside their windows
    runOne("R4 bIn ignored in second half", 16'h2468, 16'h3579, 16'h0101, 1'b1, 1'b0, 1'b0);
    runOne("R5 aIn ignored in first half", 16'hE001, 16'h6543, 16'h0F0F, 1'b0, 1'b1, 1'b0);
    runOne("R6 coef captured at frame", 16'h4321, 16'hA5C3, 16'h0000, 1'b0, 1'b0, 1'b1);

    // R7, R8, R9: corner cases
    runOne("R7 scaling min by min", 16'h8000, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0);
    runOne("R8 wrap of upper sum", 16'h7FFF, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b0);
    runOne("R9 truncation toward minus inf", 16'hFFFF, 16'h0001, 16'h0005, 1'b0, 1'b0, 1'b0);

    // R1: random words with all noise sources active
    for (int i = 0; i < 6; i++) begin
      logic [N-1:0] rb, rm, ra;
      rb = N'($urandom);
      rm = N'($urandom);
      ra = N'($urandom);
      runOne("R1 random word", rb, rm, ra, 1'b1, 1'b1, 1'b1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule